// File: doc/BRIEF.md
# Dual Threshold Alarm Monitor

This block watches a set of twelve 14-bit measurement channels and raises up to two independent alarms. Each alarm picks one channel by a 4-bit code and, on every sample strobe, compares either the channel's present level or its change over a programmable number of strobes against a signed threshold. The threshold register carries a direction bit that chooses a strictly-greater or a strictly-less comparison. One control bit chooses whether both alarms look at the filtered or the unfiltered copy of the channels.

The outcome of each alarm is kept two ways. A live condition is held from one strobe to the next and drives the output lines. A sticky status bit is set by any strobe whose comparison hits and is cleared by a read pulse. The output stage can be switched off. When it is on, it drives the OR of both live conditions onto one of two lines, either active high or active low. The unused line stays low.

The sample stream enters with a valid/ready pair. The block takes one sample on every cycle where `smp_valid_i` is high. `smp_ready_o` is held high, so the block never applies back-pressure and a sample offered is a sample taken. Control, threshold, count and status pins are plain levels.

Top module: `dual_thresh_alarm`

## Requirements
- R1: Source code 0 disables an alarm, and codes 13 to 15 also disable it. Codes 1 to 12 select, in this order, channel slots 0 to 11: supply, gyro X, gyro Y, gyro Z, accel X, accel Y, accel Z, magnetometer X, magnetometer Y, magnetometer Z, temperature, auxiliary ADC. Slot n sits at bits [14n+13:14n] of the channel buses. A disabled alarm never hits.
- R2: In level mode, the selected 14-bit value and threshold bits [13:0] are compared as two's complement numbers, and the comparison is strict. Threshold bit 15 = 1 means the alarm hits when the value is greater than the threshold. Bit 15 = 0 means it hits when the value is less than the threshold. The live condition is updated only on a strobe and holds between strobes.
- R3: When the alarm's rate bit is 1, the compared value is the present sample minus the sample taken N strobes earlier. The difference is 15-bit and signed, and the threshold is sign-extended to match. The same direction rule applies.
- R4: A count value of 0 and a count value of 1 both mean N = 1, the previous strobe.
- R5: In rate mode, an alarm cannot hit until at least N strobes have been taken since reset.
- R6: Control bit 10 = 1 makes both alarms use the filtered channels. Bit 10 = 0 makes them use the unfiltered channels.
- R7: Status bit 0 belongs to alarm A and bit 1 to alarm B. A status bit is set by a strobe whose comparison hits, and it stays set until `stat_rd_i` is pulsed. A strobe in the same cycle as the read wins. A strobe that does not hit leaves the bit unchanged.
- R8: Control bit 11 enables the outputs, bit 12 sets the polarity (1 = active high) and bit 13 selects the line (1 = `dio_o[1]`, 0 = `dio_o[0]`). The selected line carries the OR of both live conditions. The other line, and both lines while the outputs are disabled, read 0.
- R9: The two alarms are independent. Alarm A uses control bits [3:0] (source) and 8 (rate), `thr_a_i` and `cnt_a_i`. Alarm B uses bits [7:4] and 9, `thr_b_i` and `cnt_b_i`.
- R10: After reset, both live conditions and both status bits are 0.
- R11: `smp_ready_o` is 1 in every cycle, so every valid sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe (valid) |
| smp_ready_o | output | 1 | Always 1, no back-pressure |
| ch_filt_i | input | 168 | Twelve filtered 14-bit channels, slot n at [14n+13:14n] |
| ch_raw_i | input | 168 | Twelve unfiltered 14-bit channels, same layout |
| ctrl_i | input | 16 | Control: sources, rate bits, filter select, output enable/polarity/line |
| thr_a_i | input | 16 | Alarm A direction (bit 15) and threshold (bits 13:0) |
| thr_b_i | input | 16 | Alarm B direction and threshold |
| cnt_a_i | input | 8 | Alarm A rate span in strobes |
| cnt_b_i | input | 8 | Alarm B rate span in strobes |
| stat_rd_i | input | 1 | Status read pulse, clears the sticky bits |
| alm_stat_o | output | 2 | Sticky status, bit 1 = B, bit 0 = A |
| dio_o | output | 2 | Alarm output lines |

## Verification
On every cycle, the assertions check the following. A live condition changes only on a strobe. A disabled source or a rate alarm with too little history never raises its condition. A sticky bit rises only on a strobe and is cleared by a read pulse that has no strobe with it. An enabled active-high output stays low while both conditions are low. The signed arithmetic is shown only by the bench scenarios: the strict comparisons at the extremes of the 14-bit range, the exact sample that a rate comparison is taken against for a given count, the choice between filtered and unfiltered data, and the OR of two alarms on one line.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  // Control word layout; field positions are decoded by the bench and software.
  typedef struct packed {
    logic [1:0] unused_hi;  // [15:14]
    logic       line_sel;   // [13] 1 selects dio_o[1]
    logic       out_pol;    // [12] 1 active high
    logic       out_en;     // [11]
    logic       use_filt;   // [10] 1 filtered channels
    logic       rate_b;     // [9]
    logic       rate_a;     // [8]
    logic [3:0] src_b;      // [7:4]
    logic [3:0] src_a;      // [3:0]
  } alm_ctrl_t;

  localparam int unsigned N_ALARM = 2;

endpackage

// File: rtl/alarm_hist.sv
module alarm_hist #(
  parameter int unsigned DW   = 14,
  parameter int unsigned LAGW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [DW-1:0]   din_i,
  input  logic [LAGW-1:0] lag_i,
  output logic [DW-1:0]   old_o,
  output logic            ready_o
);
  localparam int unsigned DEPTH = 1 << LAGW;
  localparam int unsigned FW    = LAGW + 1;

  logic [DW-1:0]   mem [DEPTH];
  logic [LAGW-1:0] wp;
  logic [LAGW-1:0] rd_idx;
  logic [FW-1:0]   fill;

  // Newest entry sits at wp-1, so wp-lag is lag strobes back.
  assign rd_idx  = wp - lag_i;
  assign old_o   = mem[rd_idx];
  assign ready_o = (fill >= {1'b0, lag_i});

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      fill <= '0;
    end else if (push_i) begin
      wp <= wp + 1'b1;
      if (fill != FW'(DEPTH)) fill <= fill + 1'b1;
    end
  end

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  assert_fill_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i |=> $stable(fill));

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int unsigned DW   = 14,
  parameter int unsigned NCH  = 12,
  parameter int unsigned LAGW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid_i,
  input  logic [NCH*DW-1:0] chans_i,
  input  logic [3:0]        src_i,
  input  logic              rate_i,
  input  logic [15:0]       thr_i,
  input  logic [LAGW-1:0]   cnt_i,
  output logic              hit_o,
  output logic              cond_o
);
  logic            src_ok;
  logic [DW-1:0]   cur;
  logic [DW-1:0]   old;
  logic [LAGW-1:0] lag;
  logic            hist_ready;
  logic signed [DW:0] cur_s, old_s, diff_s, val_s, thr_s;
  logic            unused_thr;

  assign unused_thr = ^thr_i[14:DW];
  assign src_ok = (src_i != 4'd0) && (int'(src_i) <= NCH);

  always_comb begin
    cur = '0;
    if (src_ok) cur = chans_i[(int'(src_i) - 1) * DW +: DW];
  end

  assign lag = (cnt_i == '0) ? LAGW'(1) : cnt_i;

  alarm_hist #(.DW(DW), .LAGW(LAGW)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (smp_valid_i),
    .din_i   (cur),
    .lag_i   (lag),
    .old_o   (old),
    .ready_o (hist_ready)
  );

  assign cur_s  = {cur[DW-1], cur};
  assign old_s  = {old[DW-1], old};
  assign diff_s = cur_s - old_s;
  assign val_s  = rate_i ? diff_s : cur_s;
  assign thr_s  = {thr_i[DW-1], thr_i[DW-1:0]};

  always_comb begin
    hit_o = 1'b0;
    if (src_ok && (!rate_i || hist_ready))
      hit_o = thr_i[15] ? (val_s > thr_s) : (val_s < thr_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cond_o <= 1'b0;
    else if (smp_valid_i) cond_o <= hit_o;
  end

  assert_disabled_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && src_i == 4'd0) |=> !cond_o);

  assert_cond_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> $stable(cond_o));

  assert_no_early_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && rate_i && !hist_ready) |=> !cond_o);

endmodule

// File: rtl/dual_thresh_alarm.sv
module dual_thresh_alarm #(
  parameter int unsigned DW   = 14,
  parameter int unsigned NCH  = 12,
  parameter int unsigned LAGW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [NCH*DW-1:0] ch_filt_i,
  input  logic [NCH*DW-1:0] ch_raw_i,
  input  logic [15:0]       ctrl_i,
  input  logic [15:0]       thr_a_i,
  input  logic [15:0]       thr_b_i,
  input  logic [LAGW-1:0]   cnt_a_i,
  input  logic [LAGW-1:0]   cnt_b_i,
  input  logic              stat_rd_i,
  output logic [1:0]        alm_stat_o,
  output logic [1:0]        dio_o
);
  import alarm_pkg::*;

  alm_ctrl_t         ctrl;
  logic [NCH*DW-1:0] chans;
  logic [3:0]        src_v  [N_ALARM];
  logic              rate_v [N_ALARM];
  logic [15:0]       thr_v  [N_ALARM];
  logic [LAGW-1:0]   cnt_v  [N_ALARM];
  logic [N_ALARM-1:0] hit_w, cond_w;
  logic [1:0]        stat_q;
  logic              act, lvl;
  logic              unused_ctrl;

  assign ctrl        = alm_ctrl_t'(ctrl_i);
  assign unused_ctrl = ^ctrl.unused_hi;
  assign smp_ready_o = 1'b1;
  assign chans       = ctrl.use_filt ? ch_filt_i : ch_raw_i;

  assign src_v[0]  = ctrl.src_a;
  assign src_v[1]  = ctrl.src_b;
  assign rate_v[0] = ctrl.rate_a;
  assign rate_v[1] = ctrl.rate_b;
  assign thr_v[0]  = thr_a_i;
  assign thr_v[1]  = thr_b_i;
  assign cnt_v[0]  = cnt_a_i;
  assign cnt_v[1]  = cnt_b_i;

  for (genvar k = 0; k < N_ALARM; k++) begin : g_alm
    alarm_cmp #(.DW(DW), .NCH(NCH), .LAGW(LAGW)) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid_i (smp_valid_i),
      .chans_i     (chans),
      .src_i       (src_v[k]),
      .rate_i      (rate_v[k]),
      .thr_i       (thr_v[k]),
      .cnt_i       (cnt_v[k]),
      .hit_o       (hit_w[k]),
      .cond_o      (cond_w[k])
    );
  end

  // Sticky status: a hitting strobe outranks a read in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (smp_valid_i) stat_q <= (stat_rd_i ? 2'b00 : stat_q) | hit_w;
    else if (stat_rd_i)   stat_q <= 2'b00;
  end
  assign alm_stat_o = stat_q;

  assign act = |cond_w;
  assign lvl = ctrl.out_pol ? act : ~act;

  always_comb begin
    dio_o = 2'b00;
    if (ctrl.out_en) begin
      if (ctrl.line_sel) dio_o[1] = lvl;
      else               dio_o[0] = lvl;
    end
  end

  assert_stat_rise_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> ((alm_stat_o & ~$past(alm_stat_o)) == 2'b00));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !smp_valid_i) |=> (alm_stat_o == 2'b00));

  assert_quiet_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.out_en && ctrl.out_pol && cond_w == 2'b00) |-> (dio_o == 2'b00));

endmodule

// File: tb/test_dual_thresh_alarm.sv
`timescale 1ns/1ps
module test_dual_thresh_alarm;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_valid = 1'b0;
  logic         smp_ready;
  logic [167:0] ch_filt, ch_raw;
  logic [15:0]  ctrl = '0, thr_a = '0, thr_b = '0;
  logic [7:0]   cnt_a = '0, cnt_b = '0;
  logic         stat_rd = 1'b0;
  logic [1:0]   stat, dio;
  logic [13:0]  chf [12];
  logic [13:0]  chr [12];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 12; i++) begin
      ch_filt[i*14 +: 14] = chf[i];
      ch_raw[i*14 +: 14]  = chr[i];
    end
  end

  dual_thresh_alarm i_dual_thresh_alarm (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid), .smp_ready_o(smp_ready),
    .ch_filt_i(ch_filt), .ch_raw_i(ch_raw), .ctrl_i(ctrl),
    .thr_a_i(thr_a), .thr_b_i(thr_b), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .stat_rd_i(stat_rd), .alm_stat_o(stat), .dio_o(dio)
  );

  // {src[3:0], dir, thr[13:0], val[13:0], expected hit}
  localparam logic [33:0] VEC [9] = '{
    {4'd1,  1'b1, 14'd100,    14'd101,    1'b1},
    {4'd1,  1'b1, 14'd100,    14'd100,    1'b0},
    {4'd4,  1'b0, 14'h3FFB,   14'h3FFA,   1'b1},
    {4'd4,  1'b0, 14'h3FFB,   14'd3,      1'b0},
    {4'd12, 1'b1, 14'h1FFF,   14'h1FFF,   1'b0},
    {4'd12, 1'b1, 14'h2000,   14'h2001,   1'b1},
    {4'd0,  1'b1, 14'h2000,   14'd5,      1'b0},
    {4'd13, 1'b1, 14'h2000,   14'd5,      1'b0},
    {4'd8,  1'b0, 14'd0,      14'h3FFF,   1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_ch();
    for (int i = 0; i < 12; i++) begin chf[i] = '0; chr[i] = '0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic strobe(input bit rd);
    smp_valid = 1'b1; stat_rd = rd;
    @(negedge clk);
    smp_valid = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic read_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    clear_ch();
    do_reset();
    // R10 / R11: reset state
    check("R10 status", {14'd0, stat}, 16'h0);
    check("R10 dio", {14'd0, dio}, 16'h0);
    check("R11 ready", {15'd0, smp_ready}, 16'h1);
    ctrl = 16'h0801;  // enabled, active low, line 0
    @(negedge clk);
    check("R10 idle active-low line", {14'd0, dio}, 16'h1);

    // Table of level comparisons (R1, R2, R7)
    for (int v = 0; v < 9; v++) begin
      logic [3:0]  src;
      logic [13:0] val;
      int slot;
      src  = VEC[v][33:30];
      val  = VEC[v][14:1];
      ctrl = 16'h1C00 | {12'd0, src};
      thr_a = {VEC[v][29], 1'b0, VEC[v][28:15]};
      clear_ch();
      slot = (src == 0 || src > 12) ? 0 : int'(src) - 1;
      chf[slot] = val; chr[slot] = val;
      strobe(1'b0);
      check((src == 0 || src > 12) ? "R1 disabled" : "R2 level",
            {14'd0, dio}, {15'd0, VEC[v][0]});
      check("R7 status set", {14'd0, stat}, {15'd0, VEC[v][0]});
      read_stat();
    end

    // R3 / R5: rate mode, span 3, on gyro X (slot 1)
    do_reset(); clear_ch();
    ctrl = 16'h1D02; cnt_a = 8'd3; thr_a = 16'h8000 | 16'd10;
    chf[1] = 14'd0;  strobe(1'b0);
    chf[1] = 14'd5;  strobe(1'b0);
    chf[1] = 14'd30; strobe(1'b0);
    check("R5 no hit before history", {14'd0, dio}, 16'h0);
    chf[1] = 14'd20; strobe(1'b0);
    check("R3 rise 20 over 3", {14'd0, dio}, 16'h1);
    chf[1] = 14'd10; strobe(1'b0);
    check("R3 rise 5 below", {14'd0, dio}, 16'h0);
    thr_a = {2'b00, 14'h3FF6};
    chf[1] = 14'h3FEC; strobe(1'b0);
    check("R3 fall -50 below -10", {14'd0, dio}, 16'h1);

    // R4 / R9: alarm B, count 0 then 1, on line 1 (slot 2)
    do_reset(); clear_ch();
    ctrl = 16'h3E30; cnt_b = 8'd0; thr_b = 16'h8000;
    chf[2] = 14'd7; strobe(1'b0);
    check("R5 first strobe", {14'd0, dio}, 16'h0);
    chf[2] = 14'd9; strobe(1'b0);
    check("R4 count 0 is one", {14'd0, dio}, 16'h2);
    cnt_b = 8'd1;
    strobe(1'b0);
    check("R4 count 1 flat", {14'd0, dio}, 16'h0);
    chf[2] = 14'd12; strobe(1'b0);
    check("R4 count 1 rise", {14'd0, dio}, 16'h2);
    check("R9 only B status", {14'd0, stat}, 16'h2);

    // R6: filter select
    do_reset(); clear_ch();
    ctrl = 16'h1C01; thr_a = 16'h8064;
    chf[0] = 14'd200; chr[0] = 14'd50;
    strobe(1'b0);
    check("R6 filtered", {14'd0, dio}, 16'h1);
    ctrl = 16'h1801;
    strobe(1'b0);
    check("R6 unfiltered", {14'd0, dio}, 16'h0);

    // R7: sticky status
    ctrl = 16'h1C01; read_stat();
    check("R7 cleared", {14'd0, stat}, 16'h0);
    strobe(1'b0);
    check("R7 set", {14'd0, stat}, 16'h1);
    read_stat();
    check("R7 read clears", {14'd0, stat}, 16'h0);
    strobe(1'b0);
    check("R7 re-set", {14'd0, stat}, 16'h1);
    strobe(1'b1);
    check("R7 strobe beats read", {14'd0, stat}, 16'h1);
    chf[0] = 14'd0; strobe(1'b0);
    check("R7 miss keeps bit", {14'd0, stat}, 16'h1);
    check("R2 live cleared", {14'd0, dio}, 16'h0);

    // R8: output stage
    clear_ch();
    ctrl = 16'h1C21; thr_a = 16'h8064; thr_b = 16'h8064;
    chf[0] = 14'd200; chf[1] = 14'd200; strobe(1'b0);
    check("R8 both", {14'd0, dio}, 16'h1);
    chf[0] = 14'd0; strobe(1'b0);
    check("R8 OR keeps B", {14'd0, dio}, 16'h1);
    chf[1] = 14'd0; strobe(1'b0);
    check("R8 none", {14'd0, dio}, 16'h0);
    ctrl = 16'h0C21; @(negedge clk);
    check("R8 active low idle", {14'd0, dio}, 16'h1);
    ctrl = 16'h0421; @(negedge clk);
    check("R8 disabled", {14'd0, dio}, 16'h0);
    ctrl = 16'h3C21; chf[1] = 14'd200; strobe(1'b0);
    check("R8 line 1", {14'd0, dio}, 16'h2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule